// File: doc/BRIEF.md
# Indexed Colour Lookup Port

This block holds a colour lookup table of 2^IDX_W entries, each a red, green and blue byte, 256 entries and 768 bytes by default. A host reaches the table through four byte-wide register slots selected by `host_reg`. A write to the store-address slot selects the entry that data writes update. A write to the fetch-address slot selects the entry that data reads return. The data slot transfers one colour byte per access, in the order red, green, blue. After each complete three-byte group, the active index steps to the next entry. A whole table can therefore be loaded or dumped with a single address write followed by 768 data transfers.

The pixel side presents an index on `pix_idx` on every cycle. The matching 24-bit colour appears on `pix_rgb` after one clock edge.

When `defer_on` is high, completed host updates go to a shadow store and are marked pending. A sweep pointer then moves them into the live table only while `vretrace` is high. This keeps colour changes away from the visible part of the frame.

Top module: `clut_port`

## Requirements
- R1: A write to slot 2'b00 (store address) sets the store index. The next three writes to slot 2'b01 (data) hold red, then green, then blue, and the three bytes together form one entry. In `pix_rgb`, red sits in bits [23:16], green in [15:8] and blue in [7:0].
- R2: A write to slot 2'b11 (fetch address) sets the fetch index. The next three data-slot reads (`host_rd` high with slot 2'b01) return red, then green, then blue of that entry on `host_rdata` in the same cycle as the read strobe.
- R3: After the blue byte of a group, the active index increments by one and wraps from 255 to 0. This applies to stores and fetches alike, so 768 transfers starting at index 0 cover every entry and leave the index at 0.
- R4: A write to either address slot returns that direction's byte phase to red. Any partly written group is discarded.
- R5: An entry in the table changes only on its blue byte. The pixel port shows the old colour after the red and green bytes have been written.
- R6: `pix_rgb` holds the colour of the index presented on `pix_idx` at the previous rising clock edge.
- R7: When a blue write and a pixel lookup target the same entry at the same edge, the lookup returns the colour from before the write. The new colour appears one cycle later.
- R8: While `defer_on` is high, a completed group leaves the table unchanged as long as `vretrace` is low. Once `vretrace` has been held high for 2^IDX_W cycles, every pending entry has been committed. The table is written in deferred mode only while `vretrace` is high.
- R9: With `host_rd` low, `host_rdata` returns the store index for slot 2'b00 and the fetch index for slot 2'b11. Slot 2'b10 reads as zero, and writes to slot 2'b10 change no index.
- R10: After reset, both indices are 0, both phases are red and `pix_rgb` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_reg | input | 2 | Register slot: 00 store address, 01 data, 10 spare, 11 fetch address |
| host_wdata | input | CH_W | Host write byte |
| host_rdata | output | CH_W | Host read byte for the selected slot |
| defer_on | input | 1 | Queue host updates for commit during retrace |
| vretrace | input | 1 | Vertical retrace status |
| pix_idx | input | IDX_W | Pixel lookup index |
| pix_rgb | output | 3*CH_W | Colour looked up, one cycle late |

## Verification
The hardest case to reach from the ports is a blue write and a pixel lookup landing on the same entry at the same edge. The bench forces this by holding `pix_idx` on the entry being written and issuing the blue byte in that same cycle. It then checks that the old colour appears first and the new colour one cycle later. A second hard case is the deferred path: an entry is held pending across idle cycles with retrace low, then released by a retrace window as long as the sweep. The bench also loads, dumps and pixel-sweeps all 256 entries against a value computed from the index.

// File: rtl/clut_pkg.sv
package clut_pkg;
   typedef enum logic [1:0] {
      REG_WADDR = 2'b00,
      REG_DATA  = 2'b01,
      REG_SPARE = 2'b10,
      REG_RADDR = 2'b11
   } host_reg_e;

   typedef enum logic [1:0] {
      PH_RED = 2'd0,
      PH_GRN = 2'd1,
      PH_BLU = 2'd2
   } phase_e;
endpackage

// File: rtl/clut_seq.sv
module clut_seq #(
   parameter int IDX_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [IDX_W-1:0]  load_idx,
   input  logic              step,
   output logic [IDX_W-1:0]  idx,
   output clut_pkg::phase_e  phase
);
   import clut_pkg::*;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx   <= '0;
         phase <= PH_RED;
      end else if (load) begin
         idx   <= load_idx;
         phase <= PH_RED;
      end else if (step) begin
         case (phase)
            PH_RED:  phase <= PH_GRN;
            PH_GRN:  phase <= PH_BLU;
            default: begin
               phase <= PH_RED;
               idx   <= idx + 1'b1;
            end
         endcase
      end
   end
endmodule

// File: rtl/clut_mem.sv
module clut_mem #(
   parameter int IDX_W = 8,
   parameter int CH_W  = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                we,
   input  logic [IDX_W-1:0]    widx,
   input  logic [3*CH_W-1:0]   wdat,
   input  logic [IDX_W-1:0]    hidx,
   output logic [3*CH_W-1:0]   hdat,
   input  logic [IDX_W-1:0]    pidx,
   output logic [3*CH_W-1:0]   prgb
);
   localparam int DEPTH = 1 << IDX_W;
   localparam int PIX_W = 3 * CH_W;

   logic [PIX_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[widx] <= wdat;
   end

   assign hdat = mem[hidx];

   // read-before-write: a same-edge write is not seen by this lookup
   always_ff @(posedge clk) begin
      if (!rst_n) prgb <= '0;
      else        prgb <= mem[pidx];
   end
endmodule

// File: rtl/clut_defer.sv
module clut_defer #(
   parameter int IDX_W = 8,
   parameter int CH_W  = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                upd_v,
   input  logic [IDX_W-1:0]    upd_idx,
   input  logic [3*CH_W-1:0]   upd_val,
   input  logic                vretrace,
   output logic                cm_v,
   output logic [IDX_W-1:0]    cm_idx,
   output logic [3*CH_W-1:0]   cm_val
);
   localparam int DEPTH = 1 << IDX_W;
   localparam int PIX_W = 3 * CH_W;

   logic [PIX_W-1:0] shadow [DEPTH];
   logic [DEPTH-1:0] pend;
   logic [IDX_W-1:0] scan;

   always_ff @(posedge clk) begin
      if (upd_v) shadow[upd_idx] <= upd_val;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend <= '0;
         scan <= '0;
      end else begin
         if (vretrace) scan <= scan + 1'b1;
         if (cm_v)     pend[scan] <= 1'b0;
         // a fresh update in the same cycle keeps the entry pending
         if (upd_v)    pend[upd_idx] <= 1'b1;
      end
   end

   assign cm_v   = vretrace && pend[scan];
   assign cm_idx = scan;
   assign cm_val = shadow[scan];
endmodule

// File: rtl/clut_port.sv
module clut_port #(
   parameter int IDX_W    = 8,
   parameter int CH_W     = 8,
   parameter bit DEFER_EN = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                host_wr,
   input  logic                host_rd,
   input  logic [1:0]          host_reg,
   input  logic [CH_W-1:0]     host_wdata,
   output logic [CH_W-1:0]     host_rdata,
   input  logic                defer_on,
   input  logic                vretrace,
   input  logic [IDX_W-1:0]    pix_idx,
   output logic [3*CH_W-1:0]   pix_rgb
);
   import clut_pkg::*;

   localparam int PIX_W = 3 * CH_W;

   if (IDX_W < 1 || IDX_W > CH_W) begin : g_bad_idx
      $error("clut_port: IDX_W must be between 1 and CH_W");
   end

   host_reg_e        sel;
   logic             wa_hit, ra_hit, data_wr, data_rd;
   logic [IDX_W-1:0] wr_idx, rd_idx;
   phase_e           wr_ph, rd_ph;
   logic [CH_W-1:0]  red_q, grn_q;
   logic             host_commit;
   logic [PIX_W-1:0] commit_word, hdat;
   logic             tbl_we;
   logic [IDX_W-1:0] tbl_widx;
   logic [PIX_W-1:0] tbl_wdat;

   assign sel     = host_reg_e'(host_reg);
   assign wa_hit  = host_wr && (sel == REG_WADDR);
   assign ra_hit  = host_wr && (sel == REG_RADDR);
   assign data_wr = host_wr && (sel == REG_DATA);
   assign data_rd = host_rd && (sel == REG_DATA);

   clut_seq #(.IDX_W(IDX_W)) u_wseq (
      .clk(clk), .rst_n(rst_n), .load(wa_hit),
      .load_idx(host_wdata[IDX_W-1:0]), .step(data_wr),
      .idx(wr_idx), .phase(wr_ph)
   );

   clut_seq #(.IDX_W(IDX_W)) u_rseq (
      .clk(clk), .rst_n(rst_n), .load(ra_hit),
      .load_idx(host_wdata[IDX_W-1:0]), .step(data_rd),
      .idx(rd_idx), .phase(rd_ph)
   );

   // red and green wait here until blue arrives
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         red_q <= '0;
         grn_q <= '0;
      end else if (data_wr) begin
         if (wr_ph == PH_RED) red_q <= host_wdata;
         if (wr_ph == PH_GRN) grn_q <= host_wdata;
      end
   end

   assign host_commit = data_wr && (wr_ph == PH_BLU);
   assign commit_word = {red_q, grn_q, host_wdata};

   if (DEFER_EN) begin : g_defer
      logic             cm_v;
      logic [IDX_W-1:0] cm_idx;
      logic [PIX_W-1:0] cm_val;

      clut_defer #(.IDX_W(IDX_W), .CH_W(CH_W)) u_defer (
         .clk(clk), .rst_n(rst_n),
         .upd_v(host_commit && defer_on), .upd_idx(wr_idx), .upd_val(commit_word),
         .vretrace(vretrace),
         .cm_v(cm_v), .cm_idx(cm_idx), .cm_val(cm_val)
      );

      assign tbl_we   = defer_on ? cm_v   : host_commit;
      assign tbl_widx = defer_on ? cm_idx : wr_idx;
      assign tbl_wdat = defer_on ? cm_val : commit_word;
   end else begin : g_direct
      assign tbl_we   = host_commit;
      assign tbl_widx = wr_idx;
      assign tbl_wdat = commit_word;
   end

   clut_mem #(.IDX_W(IDX_W), .CH_W(CH_W)) u_mem (
      .clk(clk), .rst_n(rst_n),
      .we(tbl_we), .widx(tbl_widx), .wdat(tbl_wdat),
      .hidx(rd_idx), .hdat(hdat),
      .pidx(pix_idx), .prgb(pix_rgb)
   );

   always_comb begin
      case (sel)
         REG_WADDR: host_rdata = CH_W'(wr_idx);
         REG_RADDR: host_rdata = CH_W'(rd_idx);
         REG_DATA: begin
            case (rd_ph)
               PH_RED:  host_rdata = hdat[PIX_W-1 -: CH_W];
               PH_GRN:  host_rdata = hdat[2*CH_W-1 -: CH_W];
               default: host_rdata = hdat[CH_W-1:0];
            endcase
         end
         default:   host_rdata = '0;
      endcase
   end
endmodule

// File: rtl/clut_port_chk.sv
module clut_port_chk #(
   parameter int IDX_W    = 8,
   parameter int CH_W     = 8,
   parameter bit DEFER_EN = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             host_wr,
   input logic             host_rd,
   input logic [1:0]       host_reg,
   input logic [CH_W-1:0]  host_wdata,
   input logic             defer_on,
   input logic             vretrace,
   input logic [IDX_W-1:0] wr_idx,
   input logic [1:0]       wr_ph,
   input logic [IDX_W-1:0] rd_idx,
   input logic [1:0]       rd_ph,
   input logic             tbl_we
);
   // R1
   waddr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && host_reg == 2'b00) |=> (wr_idx == $past(host_wdata[IDX_W-1:0])));

   // R3
   wr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && host_reg == 2'b01 && wr_ph == 2'd2) |=>
      (wr_idx == IDX_W'($past(wr_idx) + 1'b1) && wr_ph == 2'd0));

   // R3
   rd_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && host_reg == 2'b01 && !host_wr && rd_ph == 2'd2) |=>
      (rd_idx == IDX_W'($past(rd_idx) + 1'b1) && rd_ph == 2'd0));

   // R4
   phase_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && (host_reg == 2'b00 || host_reg == 2'b11)) |=>
      (host_reg == 2'b00 ? 1'b1 : 1'b1) && ($past(host_reg) == 2'b00 ? wr_ph == 2'd0 : rd_ph == 2'd0));

   // R4
   phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ph != 2'd3) && (rd_ph != 2'd3));

   // R5
   commit_on_blue_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tbl_we && !(DEFER_EN && defer_on)) |-> (host_wr && host_reg == 2'b01 && wr_ph == 2'd2));

   // R8
   retrace_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (DEFER_EN && defer_on && tbl_we) |-> vretrace);

   // R9
   spare_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && host_reg == 2'b10 && !host_rd) |=> ($stable(wr_idx) && $stable(rd_idx)));
endmodule

bind clut_port clut_port_chk #(.IDX_W(IDX_W), .CH_W(CH_W), .DEFER_EN(DEFER_EN)) u_chk (
   .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
   .host_reg(host_reg), .host_wdata(host_wdata), .defer_on(defer_on),
   .vretrace(vretrace), .wr_idx(wr_idx), .wr_ph(wr_ph), .rd_idx(rd_idx),
   .rd_ph(rd_ph), .tbl_we(tbl_we)
);

// File: tb/clut_port_bench.sv
module clut_port_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_wr = 1'b0, host_rd = 1'b0;
   logic [1:0]  host_reg = 2'b10;
   logic [7:0]  host_wdata = '0;
   logic [7:0]  host_rdata;
   logic        defer_on = 1'b0, vretrace = 1'b0;
   logic [7:0]  pix_idx = '0;
   logic [23:0] pix_rgb;

   int n_run = 0, n_fail = 0;
   bit done = 1'b0;
   logic [23:0] model [256];

   always #2.5 clk = ~clk;

   clut_port u_clut_port (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
      .host_reg(host_reg), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .defer_on(defer_on), .vretrace(vretrace), .pix_idx(pix_idx), .pix_rgb(pix_rgb)
   );

   function automatic logic [23:0] pat(input int i);
      logic [7:0] b = 8'(i * 37 + 11);
      return {8'(i), ~8'(i), b};
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic hwrite(input logic [1:0] r, input logic [7:0] d);
      @(negedge clk);
      host_rd = 1'b0; host_wr = 1'b1; host_reg = r; host_wdata = d;
   endtask

   task automatic hread(output logic [7:0] d);
      @(negedge clk);
      host_wr = 1'b0; host_rd = 1'b1; host_reg = 2'b01;
      #1 d = host_rdata;
   endtask

   task automatic idle();
      @(negedge clk);
      host_wr = 1'b0; host_rd = 1'b0;
   endtask

   task automatic peek(input logic [1:0] r, output logic [7:0] d);
      @(negedge clk);
      host_wr = 1'b0; host_rd = 1'b0; host_reg = r;
      #1 d = host_rdata;
   endtask

   task automatic put_entry(input logic [23:0] c);
      hwrite(2'b01, c[23:16]);
      hwrite(2'b01, c[15:8]);
      hwrite(2'b01, c[7:0]);
   endtask

   task automatic pix_chk(input int i, input string req);
      idle();
      pix_idx = 8'(i);
      @(negedge clk);
      chk(pix_rgb == model[i], req, pix_rgb, model[i]);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         n_run++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      logic [23:0] got, oldc, newc;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R10 reset state
      peek(2'b00, d); chk(d == 8'h00, "R10 store index", d, 0);
      peek(2'b11, d); chk(d == 8'h00, "R10 fetch index", d, 0);
      chk(pix_rgb == 24'h0, "R10 pixel out", pix_rgb, 0);

      // R1 whole-table load with one address write
      hwrite(2'b00, 8'h00);
      for (int i = 0; i < 256; i++) begin
         put_entry(pat(i));
         model[i] = pat(i);
      end
      peek(2'b00, d); chk(d == 8'h00, "R3 store index wraps after 768", d, 0);

      // R2 whole-table dump
      hwrite(2'b11, 8'h00);
      for (int i = 0; i < 256; i++) begin
         hread(d); got[23:16] = d;
         hread(d); got[15:8]  = d;
         hread(d); got[7:0]   = d;
         chk(got == model[i], "R2 R1 dump entry", got, model[i]);
      end
      peek(2'b11, d); chk(d == 8'h00, "R3 fetch index wraps after 768", d, 0);

      // R6 pixel sweep
      for (int i = 0; i < 256; i++) pix_chk(i, "R6 pixel lookup");

      // R3 wrap from 255 to 0
      hwrite(2'b00, 8'hFF);
      put_entry(24'h123456); model[255] = 24'h123456;
      put_entry(24'hABCDEF); model[0] = 24'hABCDEF;
      pix_chk(255, "R3 entry 255");
      pix_chk(0, "R3 wrapped entry 0");
      peek(2'b00, d); chk(d == 8'h01, "R3 index after wrap", d, 1);

      // R4 address write restarts phase
      hwrite(2'b00, 8'd10);
      hwrite(2'b01, 8'h11); hwrite(2'b01, 8'h22);
      hwrite(2'b00, 8'd10);
      put_entry(24'h334455); model[10] = 24'h334455;
      pix_chk(10, "R4 partial group discarded");
      pix_chk(11, "R4 neighbour untouched");
      hwrite(2'b11, 8'd10);
      hread(d);
      hwrite(2'b11, 8'd10);
      hread(d); chk(d == 8'h33, "R4 fetch phase restarts at red", d, 8'h33);

      // R5 no change until blue
      hwrite(2'b00, 8'd12);
      hwrite(2'b01, 8'hAA); hwrite(2'b01, 8'hBB);
      pix_chk(12, "R5 old after red+green");
      hwrite(2'b01, 8'hCC); model[12] = 24'hAABBCC;
      pix_chk(12, "R5 new after blue");

      // R7 same-edge write and lookup
      oldc = model[20]; newc = 24'h5A6B7C;
      hwrite(2'b00, 8'd20);
      hwrite(2'b01, newc[23:16]); hwrite(2'b01, newc[15:8]);
      @(negedge clk);
      host_wr = 1'b1; host_reg = 2'b01; host_wdata = newc[7:0]; pix_idx = 8'd20;
      @(negedge clk);
      host_wr = 1'b0;
      chk(pix_rgb == oldc, "R7 same-edge lookup sees old", pix_rgb, oldc);
      @(negedge clk);
      chk(pix_rgb == newc, "R7 new one cycle later", pix_rgb, newc);
      model[20] = newc;

      // R8 deferred commit
      idle(); defer_on = 1'b1;
      hwrite(2'b00, 8'd30);
      put_entry(24'hC0FFEE);
      repeat (5) idle();
      pix_chk(30, "R8 held while retrace low");
      hwrite(2'b11, 8'd30);
      hread(d); chk(d == model[30][23:16], "R8 host sees old before retrace", d, model[30][23:16]);
      idle(); vretrace = 1'b1;
      repeat (258) idle();
      vretrace = 1'b0;
      model[30] = 24'hC0FFEE;
      pix_chk(30, "R8 committed in retrace");
      pix_chk(31, "R8 neighbour untouched");
      defer_on = 1'b0;

      // R9 address readback and spare slot
      hwrite(2'b00, 8'd77);
      peek(2'b00, d); chk(d == 8'd77, "R9 store index readback", d, 77);
      hwrite(2'b10, 8'hFF);
      peek(2'b00, d); chk(d == 8'd77, "R9 spare write ignored (store)", d, 77);
      peek(2'b10, d); chk(d == 8'h00, "R9 spare reads zero", d, 0);
      hwrite(2'b11, 8'd5);
      peek(2'b11, d); chk(d == 8'd5, "R9 fetch index readback", d, 5);
      hread(d); chk(d == model[5][23:16], "R2 red of entry 5", d, model[5][23:16]);
      hread(d); chk(d == model[5][15:8], "R2 green of entry 5", d, model[5][15:8]);
      idle();

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule